// File: doc/BRIEF.md
# Audio Converter Control Register Bank with Staged Updates

This block is the byte-wide configuration store of a stereo audio converter. A simple synchronous port carries an address, write data, a write strobe and a read strobe. Behind that port the block keeps an identification byte, a power register, a converter setup register, a clock-divider selector, a pre-amp output selector and one gain register per channel. It drives decoded control fields to the rest of the chip.

A freeze bit in the power register lets software change mute and both channel gains without any effect on the outputs. The new values wait in staging registers. When freeze is cleared, all of them reach the outputs on the same clock edge. Reads always return the value last written, not the value currently applied.

The block flags a reserved speed or divider code as invalid but still stores it. Reserved bits are dropped on write. Unmapped addresses read as zero.

Top module: `acfg_regbank`

## Requirements
- R1: A read of address 01h returns C0h: part code 1100b in bits 7:4 and revision 0000b in bits 3:0. Writes to 01h change nothing.
- R2: Address 02h bit 3 drives `mic_pd`, bit 2 drives `adc_pd` and bit 0 drives `dev_pd`. Bit 7 is the freeze control.
- R3: After reset, `dev_pd` is 1, 02h reads 01h, and every other output and register is 0.
- R4: Setting or clearing the device power-down bit leaves all other register contents and applied outputs unchanged.
- R5: While freeze (02h bit 7) is 1, writes to mute (04h bit 2), channel B gain (07h bits 5:0) and channel A gain (08h bits 5:0) leave `mute`, `gain_b` and `gain_a` unchanged.
- R6: The edge that writes freeze to 0 moves every staged mute and gain value to its output on that same edge. Reads of 04h, 07h and 08h return the last written value even while freeze is on.
- R7: Address 04h has these fields: bits 7:6 give `speed_mode` (00 single, 01 double, 10 quad), bit 4 gives `fmt_i2s` (0 left-justified, 1 I2S), bit 2 is mute, bit 1 gives `hpf_hold` and bit 0 gives `master_mode` (1 = master).
- R8: Address 05h bits 6:4 drive `clkdiv_sel`. The codes are 000 ÷1, 001 ÷1.5, 010 ÷2, 011 ÷3 and 100 ÷4.
- R9: Address 06h bit 6 drives `preamp_out_en`: 1 enables the amplifier output and 0 gives high impedance.
- R10: A speed code of 11 or a divider code of 101, 110 or 111 is stored and read back unchanged. `cfg_invalid` is 1 exactly while such a code is held.
- R11: Reserved bits read 0 whatever was written. Unmapped addresses read 00h, and writes to them change no register or output.
- R12: `rdata` takes the addressed value on the edge where `rd_en` is 1, using contents from before any write on that edge. It holds its value when `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| mic_pd | output | 1 | Microphone preamp power-down |
| adc_pd | output | 1 | Converter power-down |
| dev_pd | output | 1 | Whole-device power-down |
| speed_mode | output | 2 | Sample-rate range code |
| fmt_i2s | output | 1 | Serial format, 1 = I2S |
| mute | output | 1 | Applied mute |
| hpf_hold | output | 1 | High-pass filter hold |
| master_mode | output | 1 | 1 = master, 0 = slave |
| clkdiv_sel | output | 3 | Master clock divider code |
| preamp_out_en | output | 1 | Pre-amp output pin enable |
| gain_a | output | 6 | Applied channel A gain |
| gain_b | output | 6 | Applied channel B gain |
| cfg_invalid | output | 1 | Reserved speed or divider code held |

## Verification
Directed writes of all-ones show which bits each register keeps, and so tell a wrong mask apart from a wrong bit position. Writes of reserved codes show that such a code is stored and flagged, not refused. A fixed freeze sequence first checks that the outputs stay put while freeze is on, then checks that the mute and both gains change on the single edge that clears freeze. This separates a staged release from per-field release and from no staging at all. A long seeded random mix of writes, reads, freeze toggling and unmapped addresses is checked every cycle against a bench model. That mix catches address decode and read-during-write ordering errors.

// File: rtl/acfg_pkg.sv
package acfg_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int GW = 6;

  localparam logic [AW-1:0] A_ID  = 8'h01;
  localparam logic [AW-1:0] A_PWR = 8'h02;
  localparam logic [AW-1:0] A_CNV = 8'h04;
  localparam logic [AW-1:0] A_CLK = 8'h05;
  localparam logic [AW-1:0] A_PGA = 8'h06;
  localparam logic [AW-1:0] A_GB  = 8'h07;
  localparam logic [AW-1:0] A_GA  = 8'h08;

  localparam logic [3:0] PART_CODE = 4'b1100;

  // Bits that may be written; everything else is reserved.
  localparam logic [DW-1:0] K_PWR  = 8'h8D;
  localparam logic [DW-1:0] K_CNV  = 8'hD7;
  localparam logic [DW-1:0] K_CLK  = 8'h70;
  localparam logic [DW-1:0] K_PGA  = 8'h40;
  localparam logic [DW-1:0] K_GAIN = 8'h3F;

  localparam int B_FREEZE = 7;
  localparam int B_MUTE   = 2;

  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } speed_t;

  function automatic logic [DW-1:0] keep_mask(input logic [AW-1:0] a);
    case (a)
      A_PWR:      return K_PWR;
      A_CNV:      return K_CNV;
      A_CLK:      return K_CLK;
      A_PGA:      return K_PGA;
      A_GB, A_GA: return K_GAIN;
      default:    return '0;
    endcase
  endfunction

  function automatic logic speed_bad(input logic [1:0] s);
    return speed_t'(s) == SPD_RSVD;
  endfunction

  function automatic logic div_bad(input logic [2:0] d);
    return d > 3'd4;
  endfunction
endpackage

// File: rtl/acfg_stage.sv
module acfg_stage #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold_next,
  input  logic [W-1:0] stage_next,
  output logic [W-1:0] applied
);
  always_ff @(posedge clk) begin
    if (!rst_n)         applied <= '0;
    else if (!hold_next) applied <= stage_next;
  end

  p_hold_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_next |=> $stable(applied));
  p_release_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_next |=> applied == $past(stage_next));
endmodule

// File: rtl/acfg_decode.sv
module acfg_decode
  import acfg_pkg::*;
(
  input  logic [DW-1:0] pwr_q,
  input  logic [DW-1:0] cnv_q,
  input  logic [DW-1:0] clk_q,
  input  logic [DW-1:0] pga_q,
  output logic          mic_pd,
  output logic          adc_pd,
  output logic          dev_pd,
  output logic [1:0]    speed_mode,
  output logic          fmt_i2s,
  output logic          hpf_hold,
  output logic          master_mode,
  output logic [2:0]    clkdiv_sel,
  output logic          preamp_out_en,
  output logic          cfg_invalid
);
  always_comb begin
    mic_pd        = pwr_q[3];
    adc_pd        = pwr_q[2];
    dev_pd        = pwr_q[0];
    speed_mode    = cnv_q[7:6];
    fmt_i2s       = cnv_q[4];
    hpf_hold      = cnv_q[1];
    master_mode   = cnv_q[0];
    clkdiv_sel    = clk_q[6:4];
    preamp_out_en = pga_q[6];
    cfg_invalid   = speed_bad(cnv_q[7:6]) || div_bad(clk_q[6:4]);
  end
endmodule

// File: rtl/acfg_regbank.sv
module acfg_regbank
  import acfg_pkg::*;
#(
  parameter logic [3:0] REV_CODE = 4'b0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  addr,
  input  logic [7:0]  wdata,
  input  logic        wr_en,
  input  logic        rd_en,
  output logic [7:0]  rdata,
  output logic        mic_pd,
  output logic        adc_pd,
  output logic        dev_pd,
  output logic [1:0]  speed_mode,
  output logic        fmt_i2s,
  output logic        mute,
  output logic        hpf_hold,
  output logic        master_mode,
  output logic [2:0]  clkdiv_sel,
  output logic        preamp_out_en,
  output logic [5:0]  gain_a,
  output logic [5:0]  gain_b,
  output logic        cfg_invalid
);
  localparam logic [DW-1:0] ID_BYTE   = {PART_CODE, REV_CODE};
  localparam logic [DW-1:0] PWR_RESET = 8'h01;
  localparam int            NCH       = 2;

  logic [DW-1:0] pwr_q, cnv_q, clk_q, pga_q;
  logic [DW-1:0] pwr_d, cnv_d, clk_d, pga_d;
  logic [DW-1:0] gn_q [NCH];
  logic [DW-1:0] gn_d [NCH];
  logic [AW-1:0] gn_addr [NCH];
  logic [GW-1:0] gn_app [NCH];
  logic          freeze_q, freeze_d;
  logic          mapped;
  logic [DW-1:0] rd_mux;

  assign gn_addr[0] = A_GA;
  assign gn_addr[1] = A_GB;

  function automatic logic [DW-1:0] upd(input logic [DW-1:0] cur,
                                        input logic [AW-1:0] here);
    return (wr_en && addr == here) ? (wdata & keep_mask(here)) : cur;
  endfunction

  always_comb begin
    pwr_d = upd(pwr_q, A_PWR);
    cnv_d = upd(cnv_q, A_CNV);
    clk_d = upd(clk_q, A_CLK);
    pga_d = upd(pga_q, A_PGA);
    for (int c = 0; c < NCH; c++) gn_d[c] = upd(gn_q[c], gn_addr[c]);
  end

  assign freeze_q = pwr_q[B_FREEZE];
  assign freeze_d = pwr_d[B_FREEZE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pwr_q <= PWR_RESET;
      cnv_q <= '0;
      clk_q <= '0;
      pga_q <= '0;
      for (int c = 0; c < NCH; c++) gn_q[c] <= '0;
    end else begin
      pwr_q <= pwr_d;
      cnv_q <= cnv_d;
      clk_q <= clk_d;
      pga_q <= pga_d;
      for (int c = 0; c < NCH; c++) gn_q[c] <= gn_d[c];
    end
  end

  // Staged (freeze-able) fields.
  acfg_stage #(.W(1)) i_mute_stage (
    .clk(clk), .rst_n(rst_n), .hold_next(freeze_d),
    .stage_next(cnv_d[B_MUTE]), .applied(mute)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_gain
    acfg_stage #(.W(GW)) i_gain_stage (
      .clk(clk), .rst_n(rst_n), .hold_next(freeze_d),
      .stage_next(gn_d[c][GW-1:0]), .applied(gn_app[c])
    );
  end

  assign gain_a = gn_app[0];
  assign gain_b = gn_app[1];

  acfg_decode i_decode (
    .pwr_q(pwr_q), .cnv_q(cnv_q), .clk_q(clk_q), .pga_q(pga_q),
    .mic_pd(mic_pd), .adc_pd(adc_pd), .dev_pd(dev_pd),
    .speed_mode(speed_mode), .fmt_i2s(fmt_i2s), .hpf_hold(hpf_hold),
    .master_mode(master_mode), .clkdiv_sel(clkdiv_sel),
    .preamp_out_en(preamp_out_en), .cfg_invalid(cfg_invalid)
  );

  // Read path: current contents, registered on the read strobe.
  always_comb begin
    mapped = 1'b1;
    case (addr)
      A_ID:  rd_mux = ID_BYTE;
      A_PWR: rd_mux = pwr_q;
      A_CNV: rd_mux = cnv_q;
      A_CLK: rd_mux = clk_q;
      A_PGA: rd_mux = pga_q;
      A_GA:  rd_mux = gn_q[0];
      A_GB:  rd_mux = gn_q[1];
      default: begin
        rd_mux = '0;
        mapped = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  p_id_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_ID) |=> rdata == ID_BYTE);
  p_reset_pd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (dev_pd && !mute && gain_a == '0 && gain_b == '0));
  p_frozen_gain_r5: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_q |-> ($stable(gain_a) && $stable(gain_b) && $stable(mute)));
  p_unfrozen_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze_q |-> (gain_a == gn_q[0][GW-1:0] && gain_b == gn_q[1][GW-1:0]
                   && mute == cnv_q[B_MUTE]));
  p_invalid_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_invalid == (speed_mode == 2'b11 || clkdiv_sel >= 3'd5));
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mapped) |=> rdata == '0);
  p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/test_acfg_regbank.sv
module test_acfg_regbank;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rdata;
  logic mic_pd, adc_pd, dev_pd, fmt_i2s, mute, hpf_hold, master_mode;
  logic preamp_out_en, cfg_invalid;
  logic [1:0] speed_mode;
  logic [2:0] clkdiv_sel;
  logic [5:0] gain_a, gain_b;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] m_reg [16];
  logic       m_mute;
  logic [5:0] m_ga, m_gb;
  logic [7:0] m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  acfg_regbank i_acfg_regbank (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .mic_pd(mic_pd), .adc_pd(adc_pd), .dev_pd(dev_pd),
    .speed_mode(speed_mode), .fmt_i2s(fmt_i2s), .mute(mute),
    .hpf_hold(hpf_hold), .master_mode(master_mode),
    .clkdiv_sel(clkdiv_sel), .preamp_out_en(preamp_out_en),
    .gain_a(gain_a), .gain_b(gain_b), .cfg_invalid(cfg_invalid)
  );

  function automatic logic [7:0] b_mask(input logic [7:0] a);
    if (a == 8'h02) return 8'b1000_1101;
    if (a == 8'h04) return 8'b1101_0111;
    if (a == 8'h05) return 8'b0111_0000;
    if (a == 8'h06) return 8'b0100_0000;
    if (a == 8'h07 || a == 8'h08) return 8'b0011_1111;
    return 8'h00;
  endfunction

  function automatic logic [7:0] b_read(input logic [7:0] a);
    if (a == 8'h01) return 8'hC0;
    if (b_mask(a) != 0) return m_reg[a[3:0]];
    return 8'h00;
  endfunction

  function automatic logic [25:0] b_outs();
    logic [7:0] p, c, k;
    logic bad;
    p = m_reg[2]; c = m_reg[4]; k = m_reg[5];
    bad = (c[7:6] == 2'b11) || (k[6:4] inside {3'd5, 3'd6, 3'd7});
    return {p[3], p[2], p[0], c[7:6], c[4], m_mute, c[1], c[0],
            k[6:4], m_reg[6][6], m_ga, m_gb, bad};
  endfunction

  function automatic logic [25:0] dut_outs();
    return {mic_pd, adc_pd, dev_pd, speed_mode, fmt_i2s, mute, hpf_hold,
            master_mode, clkdiv_sel, preamp_out_en, gain_a, gain_b, cfg_invalid};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
    m_reg[2] = 8'h01;
    m_mute = 0; m_ga = 0; m_gb = 0; m_rd = 0;
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_model(input string tag);
    check({tag, " outputs"}, {6'd0, dut_outs()}, {6'd0, b_outs()});
    check({tag, " rdata"}, {24'd0, rdata}, {24'd0, m_rd});
  endtask

  // One bus cycle: inputs driven at a falling edge, results seen at the next.
  task automatic op(input bit w, input bit r, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = w; rd_en = r; addr = a; wdata = d;
    @(posedge clk);
    if (r) m_rd = b_read(a);
    if (w && b_mask(a) != 0) m_reg[a[3:0]] = d & b_mask(a);
    if (!m_reg[2][7]) begin
      m_mute = m_reg[4][2]; m_ga = m_reg[8][5:0]; m_gb = m_reg[7][5:0];
    end
    @(negedge clk);
    wr_en = 0; rd_en = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d); op(1, 0, a, d); endtask
  task automatic rd(input logic [7:0] a); op(0, 1, a, 8'h00); endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [5:0] ga_before, gb_before;
    void'($urandom(32'd5150));
    model_reset();
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3: reset state
    check("R3 reset outputs", {6'd0, dut_outs()}, {6'd0, 26'b0010_0000_0000_0000_0000_0000_00});
    rd(8'h02); check("R3 power reg reset", rdata, 8'h01);

    // R1: identification byte, read-only
    rd(8'h01); check("R1 id read", rdata, 8'hC0);
    wr(8'h01, 8'hFF); rd(8'h01); check("R1 id after write", rdata, 8'hC0);

    // R2, R11: power register fields and reserved bits
    wr(8'h02, 8'h7D); rd(8'h02); check("R11 power reserved", rdata, 8'h0D);
    check("R2 pd bits", {mic_pd, adc_pd, dev_pd}, 3'b111);
    wr(8'h02, 8'h04);
    check("R2 adc only", {mic_pd, adc_pd, dev_pd}, 3'b010);

    // R7: converter register
    wr(8'h04, 8'h93);
    check("R7 fields", {speed_mode, fmt_i2s, mute, hpf_hold, master_mode}, 6'b10_1011);
    rd(8'h04); check("R7 readback", rdata, 8'h93);
    wr(8'h04, 8'h6D);
    check("R7 fields b", {speed_mode, fmt_i2s, mute, hpf_hold, master_mode}, 6'b01_0101);

    // R8, R10: divider and reserved codes
    wr(8'h05, 8'hC0); check("R8 div4", {clkdiv_sel, cfg_invalid}, 4'b100_0);
    wr(8'h05, 8'h50); check("R10 div reserved", {clkdiv_sel, cfg_invalid}, 4'b101_1);
    rd(8'h05); check("R10 div stored", rdata, 8'h50);
    wr(8'h05, 8'h10); check("R8 div1.5", {clkdiv_sel, cfg_invalid}, 4'b001_0);
    wr(8'h04, 8'hC0); check("R10 speed reserved", {speed_mode, cfg_invalid}, 3'b11_1);
    rd(8'h04); check("R10 speed stored", rdata, 8'hC0);

    // R9: pre-amp output select
    wr(8'h06, 8'hFF); check("R9 enable", preamp_out_en, 1'b1);
    rd(8'h06); check("R11 pga reserved", rdata, 8'h40);

    // R11: unmapped addresses
    wr(8'h03, 8'hFF); wr(8'hA5, 8'hFF); wr(8'h00, 8'hFF);
    check_model("R11 unmapped write");
    rd(8'h03); check("R11 unmapped read", rdata, 8'h00);

    // R5, R6: staged mute and gains
    wr(8'h07, 8'h05); wr(8'h08, 8'h09); wr(8'h04, 8'h00);
    wr(8'h02, 8'h80);
    ga_before = gain_a; gb_before = gain_b;
    wr(8'h07, 8'h3F); wr(8'h08, 8'h2A); wr(8'h04, 8'h04);
    check("R5 frozen", {mute, gain_a, gain_b}, {1'b0, ga_before, gb_before});
    rd(8'h08); check("R6 read shows written", rdata, 8'h2A);
    @(negedge clk); wr_en = 1; addr = 8'h02; wdata = 8'h00;
    @(posedge clk); #1;
    check("R6 release same edge", {mute, gain_a, gain_b}, {1'b1, 6'h2A, 6'h3F});
    @(negedge clk); wr_en = 0;
    m_reg[2] = 8'h00; m_mute = 1; m_ga = 6'h2A; m_gb = 6'h3F;

    // R4: power-down keeps contents
    wr(8'h02, 8'h01); wr(8'h02, 8'h00);
    check_model("R4 retained");
    rd(8'h07); check("R4 gain kept", rdata, 8'h3F);

    // R12: rdata holds without read strobe
    rd(8'h05);
    op(0, 0, 8'h01, 8'h00);
    check("R12 hold", rdata, 8'h10);
    op(1, 1, 8'h07, 8'h11); check("R12 read before write", rdata, 8'h3F);

    // Random mix
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a, d;
      a = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 10);
      d = 8'($urandom);
      if (a == 8'h02 && ($urandom % 2 == 0)) d[0] = 1'b0;
      op(1'($urandom % 2), 1'($urandom % 2), a, d);
      check_model("R5 R6 R7 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule